// File: doc/BRIEF.md
# Oscillator Trim Calibration Controller

This block finds a good setting for the 8-bit trim code of an on-chip oscillator without software help. The oscillator's own output is the block's clock. An external reference supplies long high pulses of known width. The block counts how many cycles of its clock fit inside one pulse and compares that count with a programmed expected value. It turns the relative error into a number of trim steps and applies the correction. A larger trim code means a slower oscillator. The measure-and-adjust loop repeats on the following pulses until the remaining error is below half a step or a fixed number of adjustments has been made.

One trim step moves the frequency by roughly 0.195 % of the untrimmed value, which is close to 1/512. The step count is therefore computed in fixed point as `|count - expected| * 512 / expected`, rounded to nearest. When the oscillator is slow, fewer cycles are counted and the code is lowered. When it is fast, the code is raised. A correction that would leave the code range pins the code at the limit and ends the run with the failed flag.

Top module: `osc_trim_cal`

## Requirements
- R1: While reset is high and after it is released, the trim code is 0x80, and busy, done and failed are all low.
- R2: A start strobe while busy is low sets busy on the next cycle and clears done and failed. The trim code keeps its present value and is not restored to 0x80.
- R3: After start, the block waits for a rising edge of the synchronised reference. It then measures the pulse as the number of clock cycles the reference is high, as seen through a two-flop synchroniser.
- R4: The step magnitude is round-to-nearest of |count - expected| * 512 / expected. It is added to the trim code when the count exceeds the expected value and subtracted when the count is below it.
- R5: A measurement whose step magnitude is 0 ends the run: busy falls, done rises and the trim code is unchanged. Done then holds until the next accepted start.
- R6: A correction that would take the code below 0 or above 255 sets the code to 0 or 255 respectively. Failed rises, busy falls and done stays low.
- R7: At most 8 corrections are applied per run. After the 8th in-range correction, busy falls and done rises even if the last step was non-zero.
- R8: A start strobe while busy is high has no effect on the run, the iteration count or the flags.
- R9: The pulse count saturates at twice the expected count instead of wrapping. A too-long pulse therefore yields a large positive error.
- R10: Busy is high exactly from the cycle after an accepted start up to the cycle in which done or failed rises. Done and failed are never high while busy is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Trimmed oscillator clock; all logic runs on it |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a calibration run |
| ref_pulse | input | 1 | Asynchronous external reference pulse |
| expected_count | input | 24 | Cycle count that a correctly trimmed clock gives over one pulse |
| trim | output | 8 | Trim code to the oscillator; larger value means lower frequency |
| busy | output | 1 | Calibration run in progress |
| done | output | 1 | Run ended with error within one step or after the iteration limit |
| failed | output | 1 | Run ended because the trim code hit a range limit |

## Verification
The assertions assume that `expected_count` is non-zero and does not change while busy is high. They also assume that the reference stays low for a few cycles between pulses, so that every rise and fall is seen by the synchroniser. The stimulus changes `expected_count` only while the block is idle, always uses values of 100 or more, and separates pulses by several low cycles. Pulses are driven on the falling clock edge. This gives each pulse an exact cycle width, which the bench's behavioural model reproduces through a short queue of past reference samples.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;

    localparam int TRIM_WIDTH  = 8;
    localparam int COUNT_WIDTH = 24;
    localparam int STEP_SHIFT  = 9;   // one step ~ 1/512 of nominal
    localparam int ITER_LIMIT  = 8;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        CAL_IDLE   = 2'd0,
        CAL_ARM    = 2'd1,
        CAL_COUNT  = 2'd2,
        CAL_ADJUST = 2'd3
    } cal_state_e;

    // Rounded step magnitude plus its direction
    typedef struct packed {
        logic        lower;   // 1: subtract from the code (clock slow)
        logic [15:0] mag;
    } trim_step_t;

    function automatic logic [15:0] sat_mag(input logic [63:0] q, input int width);
        logic [15:0] lim;
        lim = 16'((64'd1 << width) - 64'd1);
        return (q > 64'(lim)) ? lim : q[15:0];
    endfunction

endpackage

// File: rtl/ref_edge_sync.sv
module ref_edge_sync #(
    parameter int STAGES = osc_trim_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level,
    output logic rise
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              hist_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= async_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) hist_q <= 1'b0;
        else     hist_q <= chain_q[LAST];
    end

    assign level = chain_q[LAST];
    assign rise  = chain_q[LAST] & ~hist_q;
endmodule

// File: rtl/pulse_width_counter.sv
module pulse_width_counter #(
    parameter int CNT_W = osc_trim_pkg::COUNT_WIDTH
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load_one,
    input  logic           advance,
    input  logic [CNT_W:0] ceiling,
    output logic [CNT_W:0] count
);
    logic [CNT_W:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (load_one) begin
            count_q <= {{CNT_W{1'b0}}, 1'b1};
        end else if (advance) begin
            if (count_q >= ceiling) count_q <= ceiling;
            else                    count_q <= count_q + 1'b1;
        end
    end

    assign count = count_q;
endmodule

// File: rtl/trim_step_calc.sv
module trim_step_calc #(
    parameter int CNT_W  = osc_trim_pkg::COUNT_WIDTH,
    parameter int SHIFT  = osc_trim_pkg::STEP_SHIFT,
    parameter int STEP_W = osc_trim_pkg::STEP_SHIFT + 2
) (
    input  logic [CNT_W:0]      measured,
    input  logic [CNT_W-1:0]    nominal,
    output osc_trim_pkg::trim_step_t step
);
    localparam int NUM_W = CNT_W + SHIFT + 2;

    logic [CNT_W:0]   nominal_x;
    logic [CNT_W:0]   diff_abs;
    logic             slow;
    logic [NUM_W-1:0] numer;
    logic [NUM_W-1:0] quot;

    always_comb begin
        nominal_x = {1'b0, nominal};
        slow      = measured < nominal_x;
        diff_abs  = slow ? (nominal_x - measured) : (measured - nominal_x);
        numer     = (NUM_W'(diff_abs) << SHIFT) + NUM_W'(nominal >> 1);
        quot      = (nominal == '0) ? '0 : numer / NUM_W'(nominal);
        step.lower = slow;
        step.mag   = osc_trim_pkg::sat_mag(64'(quot), STEP_W);
    end
endmodule

// File: rtl/osc_trim_cal.sv
module osc_trim_cal
    import osc_trim_pkg::*;
#(
    parameter int TRIM_W   = TRIM_WIDTH,
    parameter int CNT_W    = COUNT_WIDTH,
    parameter int MAX_ITER = ITER_LIMIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              ref_pulse,
    input  logic [CNT_W-1:0]  expected_count,
    output logic [TRIM_W-1:0] trim,
    output logic              busy,
    output logic              done,
    output logic              failed
);
    localparam int STEP_W = STEP_SHIFT + 2;
    localparam int SUM_W  = ((TRIM_W > STEP_W) ? TRIM_W : STEP_W) + 2;
    localparam int ITER_W = $clog2(MAX_ITER + 1);
    localparam logic [TRIM_W-1:0] TRIM_MID = {1'b1, {(TRIM_W-1){1'b0}}};
    localparam logic [TRIM_W-1:0] TRIM_TOP = {TRIM_W{1'b1}};

    cal_state_e        state_q;
    logic [TRIM_W-1:0] trim_q;
    logic [ITER_W-1:0] iter_q;
    logic              done_q, failed_q;

    logic              ref_level, ref_rise;
    logic [CNT_W:0]    width_cnt;
    trim_step_t        step;

    logic signed [SUM_W-1:0] code_s, step_s, next_s, top_s;
    logic                    below, above, last_iter;

    ref_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst      (rst),
        .async_in (ref_pulse),
        .level    (ref_level),
        .rise     (ref_rise)
    );

    pulse_width_counter #(.CNT_W(CNT_W)) width_i (
        .clk      (clk),
        .rst      (rst),
        .load_one (state_q == CAL_ARM && ref_rise),
        .advance  (state_q == CAL_COUNT && ref_level),
        .ceiling  ({expected_count, 1'b0}),
        .count    (width_cnt)
    );

    trim_step_calc #(.CNT_W(CNT_W), .SHIFT(STEP_SHIFT), .STEP_W(STEP_W)) calc_i (
        .measured (width_cnt),
        .nominal  (expected_count),
        .step     (step)
    );

    always_comb begin
        code_s    = $signed({{(SUM_W-TRIM_W){1'b0}}, trim_q});
        step_s    = $signed({{(SUM_W-STEP_W){1'b0}}, step.mag[STEP_W-1:0]});
        top_s     = $signed({{(SUM_W-TRIM_W){1'b0}}, TRIM_TOP});
        next_s    = step.lower ? (code_s - step_s) : (code_s + step_s);
        below     = next_s < 0;
        above     = next_s > top_s;
        last_iter = (iter_q == ITER_W'(MAX_ITER - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= CAL_IDLE;
            trim_q   <= TRIM_MID;
            iter_q   <= '0;
            done_q   <= 1'b0;
            failed_q <= 1'b0;
        end else begin
            unique case (state_q)
                CAL_IDLE: begin
                    if (start) begin
                        state_q  <= CAL_ARM;
                        iter_q   <= '0;
                        done_q   <= 1'b0;
                        failed_q <= 1'b0;
                    end
                end
                CAL_ARM: begin
                    if (ref_rise) state_q <= CAL_COUNT;
                end
                CAL_COUNT: begin
                    if (!ref_level) state_q <= CAL_ADJUST;
                end
                CAL_ADJUST: begin
                    if (step.mag == '0) begin
                        done_q  <= 1'b1;
                        state_q <= CAL_IDLE;
                    end else if (below) begin
                        trim_q   <= '0;
                        failed_q <= 1'b1;
                        state_q  <= CAL_IDLE;
                    end else if (above) begin
                        trim_q   <= TRIM_TOP;
                        failed_q <= 1'b1;
                        state_q  <= CAL_IDLE;
                    end else begin
                        trim_q <= next_s[TRIM_W-1:0];
                        if (last_iter) begin
                            done_q  <= 1'b1;
                            state_q <= CAL_IDLE;
                        end else begin
                            iter_q  <= iter_q + 1'b1;
                            state_q <= CAL_ARM;
                        end
                    end
                end
                default: state_q <= CAL_IDLE;
            endcase
        end
    end

    assign trim   = trim_q;
    assign busy   = (state_q != CAL_IDLE);
    assign done   = done_q;
    assign failed = failed_q;
endmodule

// File: rtl/osc_trim_cal_chk.sv
module osc_trim_cal_chk #(
    parameter int TRIM_W   = 8,
    parameter int MAX_ITER = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [TRIM_W-1:0] trim,
    input logic              busy,
    input logic              done,
    input logic              failed
);
    logic [TRIM_W-1:0] trim_prev;
    logic [7:0]        moves;

    always_ff @(posedge clk) begin
        if (rst) begin
            trim_prev <= trim;
            moves     <= '0;
        end else begin
            trim_prev <= trim;
            if (!busy && start)       moves <= '0;
            else if (trim != trim_prev && moves != 8'hFF) moves <= moves + 1'b1;
        end
    end

    // R10
    busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!done && !failed));

    // R5
    end_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done != failed));

    // R5
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !busy && !start) |=> done);

    // R2
    trim_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> $stable(trim));

    // R7
    iter_cap_chk: assert property (@(posedge clk) disable iff (rst)
        moves <= 8'(MAX_ITER));
endmodule

bind osc_trim_cal osc_trim_cal_chk #(.TRIM_W(TRIM_W), .MAX_ITER(MAX_ITER)) chk_i (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .trim   (trim),
    .busy   (busy),
    .done   (done),
    .failed (failed)
);

// File: tb/osc_trim_cal_tb.sv
module osc_trim_cal_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        ref_in = 1'b0;
    logic [23:0] exp_cnt = 24'd1000;
    logic [7:0]  trim;
    logic        busy, done, failed;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;   // 50 MHz

    osc_trim_cal dut_i (
        .clk            (clk),
        .rst            (rst),
        .start          (start),
        .ref_pulse      (ref_in),
        .expected_count (exp_cnt),
        .trim           (trim),
        .busy           (busy),
        .done           (done),
        .failed         (failed)
    );

    // Behavioural reference: phase 0 idle, 1 waiting, 2 measuring, 3 correcting
    int  m_phase = 0;
    int  m_trim = 128;
    int  m_iter = 0;
    longint m_cnt = 0;
    bit  m_done = 0, m_failed = 0;
    int  hist[$] = '{0, 0, 0};

    always @(posedge clk) begin
        int lvl, prv;
        longint e, mag, nxt, lim;
        lvl = hist[1];
        prv = hist[2];
        lim = 2 * longint'(exp_cnt);
        if (rst) begin
            m_phase = 0; m_trim = 128; m_iter = 0; m_cnt = 0;
            m_done = 0; m_failed = 0;
            hist = '{0, 0, 0};
        end else begin
            case (m_phase)
                0: if (start) begin
                    m_phase = 1; m_iter = 0; m_done = 0; m_failed = 0;
                end
                1: if (lvl == 1 && prv == 0) begin m_cnt = 1; m_phase = 2; end
                2: if (lvl == 1) m_cnt = (m_cnt >= lim) ? lim : m_cnt + 1;
                   else m_phase = 3;
                default: begin
                    e   = m_cnt - longint'(exp_cnt);
                    mag = (((e < 0) ? -e : e) * 512 + longint'(exp_cnt) / 2) / longint'(exp_cnt);
                    nxt = (e < 0) ? m_trim - mag : m_trim + mag;
                    if (mag == 0) begin m_done = 1; m_phase = 0; end
                    else if (nxt < 0) begin m_trim = 0; m_failed = 1; m_phase = 0; end
                    else if (nxt > 255) begin m_trim = 255; m_failed = 1; m_phase = 0; end
                    else begin
                        m_trim = int'(nxt);
                        m_iter++;
                        if (m_iter == 8) begin m_done = 1; m_phase = 0; end
                        else m_phase = 1;
                    end
                end
            endcase
            hist.push_front(int'(ref_in));
            void'(hist.pop_back());
        end
    end

    task automatic check(input string tag, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, expv, cycles);
        end
    endtask

    // Per-clock comparison with the model, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            check("R4 trim vs model", trim, m_trim);
            check("R10 busy vs model", busy, m_phase != 0);
            check("R5 done vs model", done, m_done);
            check("R6 failed vs model", failed, m_failed);
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic kick();
        start = 1'b1; tick(1); start = 1'b0;
    endtask

    task automatic pulse(input int width);
        tick(6);
        ref_in = 1'b1; tick(width); ref_in = 1'b0;
        tick(6);
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_up();
        end
    end

    initial begin
        tick(4);
        // R1: values during reset
        check("R1 trim in reset", trim, 8'h80);
        check("R1 busy in reset", busy, 0);
        rst = 1'b0;
        tick(2);
        check("R1 trim after reset", trim, 8'h80);
        check("R1 flags after reset", {busy, done, failed}, 0);

        // Slow clock then on target: 990 of 1000 -> step 5 down
        exp_cnt = 24'd1000;
        kick();
        check("R2 busy after start", busy, 1);
        pulse(990);
        check("R3 R4 slow correction", trim, 123);
        check("R7 still running", busy, 1);
        pulse(1000);
        check("R5 zero step done", {busy, done, failed}, 3'b010);
        check("R5 code unchanged", trim, 123);
        tick(5);
        check("R5 done holds", done, 1);

        // Fast clock, with a start strobe in the middle of the run
        kick();
        check("R2 done cleared, code kept", {done, trim}, {1'b0, 8'd123});
        tick(6);
        ref_in = 1'b1; tick(400);
        start = 1'b1; tick(1); start = 1'b0;   // R8: ignored
        tick(609); ref_in = 1'b0; tick(6);
        check("R8 R4 fast correction", trim, 128);
        check("R8 still busy", busy, 1);
        pulse(1000);
        check("R8 ends with done", {busy, done}, 2'b01);

        // Iteration limit: 201 of 200 -> +3 each time, 8 times
        exp_cnt = 24'd200;
        kick();
        for (int k = 0; k < 8; k++) pulse(201);
        check("R7 limit code", trim, 152);
        check("R7 limit flags", {busy, done, failed}, 3'b010);

        // Lower clamp: 40 of 100 -> step 307 down
        exp_cnt = 24'd100;
        kick();
        pulse(40);
        check("R6 lower clamp code", trim, 0);
        check("R6 lower clamp flags", {busy, done, failed}, 3'b001);

        // Upper clamp with saturating count: 300 of 100 -> count 200
        kick();
        check("R2 failed cleared", failed, 0);
        pulse(300);
        check("R9 R6 upper clamp code", trim, 255);
        check("R9 R6 upper clamp flags", {busy, done, failed}, 3'b001);

        // Exactly nominal from the top code: done without motion
        kick();
        pulse(100);
        check("R5 exact pulse", {trim, done}, {8'd255, 1'b1});

        tick(4);
        finish_up();
    end
endmodule